// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block orders the transactions waiting to cross one direction of a bus-to-bus bridge. Each accepted transaction carries one of five classes: posted write, delayed read request, delayed write request, delayed read completion or delayed write completion. The queue stores the class and an arrival tag for up to `DEPTH` transactions and, on every cycle, offers one of them to the target side. The offer is the oldest entry that is permitted to pass every older entry still waiting and that the target has not recently declined.

Transactions enter on a valid/ready handshake. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low whenever the queue holds `DEPTH` entries; the source must then hold its request. The target side sees `out_valid` together with the offered class, slot and tag. It either accepts the offer with `out_ready`, which removes the entry, or declines it with `out_skip`. A decline moves the offer to another entry that may legally pass the older ones.

Top module: `txo_order_queue`

## Requirements
- R1: Class codes on `in_class` and `out_class` are 0 posted write, 1 delayed read request, 2 delayed write request, 3 delayed read completion, 4 delayed write completion. An entry is stored with its class when `in_valid` and `in_ready` are both high at a clock edge.
- R2: A posted write is never offered while an older posted write is waiting, so posted writes leave in arrival order.
- R3: Relative to an older posted write, only a delayed write completion may be offered. Delayed read requests, delayed write requests and delayed read completions must wait.
- R4: A posted write may pass an older delayed read request only when that request is the oldest delayed request (class 1 or 2) in the queue.
- R5: Relative to an older delayed write request, posted writes and both completion classes may pass. Neither request class may pass it.
- R6: Relative to an older completion of either kind, posted writes and both request classes may pass. No completion may pass an older completion.
- R7: Relative to an older delayed read request, both request classes and the delayed write completion may pass. A delayed read completion may not.
- R8: An entry is eligible when the rules of R2 to R7 let it pass every older entry. The offer goes to the lowest-slot eligible entry that is not marked declined, and `out_valid` is high exactly when the queue is not empty. Slot 0 always holds the oldest entry.
- R9: With `DEPTH` entries stored, `in_ready` is low and `full` is high. Any enqueue on that edge is refused and leaves the contents unchanged, even when the same edge removes an entry.
- R10: When `out_ready` is high with `out_valid`, the offered entry is removed and the younger entries move down one slot in their original relative order. A removal clears every decline mark.
- R11: `out_skip` without `out_ready` marks the offered entry as declined. If no other undeclined eligible entry exists, it clears all marks instead. `out_ready` takes precedence over `out_skip`.
- R12: After reset the queue is empty, `in_ready` is high, `full` is low, and the first accepted entry receives tag 0. Each later accepted entry receives the next tag, modulo 2^`TAG_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source has a transaction to enqueue |
| in_class | input | 3 | Class code of the offered transaction |
| in_ready | output | 1 | Queue can accept a transaction this cycle |
| full | output | 1 | Queue holds DEPTH entries |
| out_valid | output | 1 | An entry is offered to the target side |
| out_class | output | 3 | Class code of the offered entry |
| out_idx | output | $clog2(DEPTH) | Slot of the offered entry, 0 is oldest |
| out_tag | output | TAG_W | Arrival tag of the offered entry |
| out_ready | input | 1 | Target accepts the offered entry |
| out_skip | input | 1 | Target declines the offered entry |

## Verification
Short two- and three-entry patterns are loaded with the target side idle and then declined once. Whether the offer moves away from slot 0 shows, pair by pair, which later class may pass which earlier one. The request-then-posted-write pair is run twice, once with the request at the head of the delayed queue and once behind a write request, to tell the conditional permission apart from a plain yes or no. Repeated declines across mixed patterns show that ineligible middle slots are skipped and that marks wrap around. A fill-to-capacity pattern with enqueues during full, and a removal from the middle of the queue followed by a drain, distinguish refusal from overwrite and order-preserving compaction from reordering. A long random run of enqueues, accepts and declines is compared every cycle with a behavioural queue model.

// File: rtl/txo_pkg.sv
package txo_pkg;

  localparam int TXO_CLS_W = 3;

  typedef enum logic [TXO_CLS_W-1:0] {
    TXC_PW    = 3'd0,
    TXC_RDREQ = 3'd1,
    TXC_WRREQ = 3'd2,
    TXC_RDCPL = 3'd3,
    TXC_WRCPL = 3'd4
  } txo_cls_e;

  // Whether a later transaction may be issued ahead of an earlier one.
  function automatic logic txo_may_pass(txo_cls_e later, txo_cls_e earlier,
                                        logic earlier_is_dhead);
    logic ok;
    case (earlier)
      TXC_PW:    ok = (later == TXC_WRCPL);
      TXC_RDREQ: ok = (later == TXC_PW) ? earlier_is_dhead : (later != TXC_RDCPL);
      TXC_WRREQ: ok = (later == TXC_PW) || (later == TXC_RDCPL) || (later == TXC_WRCPL);
      default:   ok = (later == TXC_PW) || (later == TXC_RDREQ) || (later == TXC_WRREQ);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/txo_elig.sv
module txo_elig
  import txo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH*TXO_CLS_W-1:0] cls_flat,
  output logic [DEPTH-1:0]           elig
);

  logic [DEPTH-1:0] is_dreq;
  logic [DEPTH-1:0] dhead;

  for (genvar j = 0; j < DEPTH; j++) begin : g_dreq
    txo_cls_e c;
    assign c = txo_cls_e'(cls_flat[j*TXO_CLS_W +: TXO_CLS_W]);
    assign is_dreq[j] = vld[j] && ((c == TXC_RDREQ) || (c == TXC_WRREQ));
  end

  // Oldest delayed request in the queue.
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      dhead[j] = is_dreq[j] && !seen;
      seen     = seen | is_dreq[j];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_comb begin
      logic ok;
      ok = vld[i];
      for (int j = 0; j < i; j++) begin
        if (vld[j] && !txo_may_pass(txo_cls_e'(cls_flat[i*TXO_CLS_W +: TXO_CLS_W]),
                                    txo_cls_e'(cls_flat[j*TXO_CLS_W +: TXO_CLS_W]),
                                    dhead[j]))
          ok = 1'b0;
      end
      elig[i] = ok;
    end
  end

endmodule

// File: rtl/txo_pick.sv
module txo_pick #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/txo_order_queue.sv
module txo_order_queue
  import txo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [2:0]                   in_class,
  output logic                         in_ready,
  output logic                         full,
  output logic                         out_valid,
  output logic [2:0]                   out_class,
  output logic [$clog2(DEPTH)-1:0]     out_idx,
  output logic [TAG_W-1:0]             out_tag,
  input  logic                         out_ready,
  input  logic                         out_skip
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [TXO_CLS_W-1:0] cls_q [DEPTH];
  logic [TAG_W-1:0]     tag_q [DEPTH];
  logic [DEPTH-1:0]     blk_q;
  logic [TAG_W-1:0]     tag_ctr_q;

  logic [DEPTH-1:0]           vld, elig, cand, sel_oh;
  logic [DEPTH*TXO_CLS_W-1:0] cls_flat;
  logic                       cand_found, others;
  logic [IDX_W-1:0]           cand_idx, sel_idx;
  logic                       acc_in, deq, skip;
  logic [CNT_W-1:0]           cnt_mid;

  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    assign vld[i] = cnt_q > CNT_W'(i);
    assign cls_flat[i*TXO_CLS_W +: TXO_CLS_W] = cls_q[i];
  end

  txo_elig #(.DEPTH(DEPTH)) u_elig (
    .vld      (vld),
    .cls_flat (cls_flat),
    .elig     (elig)
  );

  assign cand = elig & ~blk_q;

  txo_pick #(.W(DEPTH), .IDX_W(IDX_W)) u_pick (
    .req   (cand),
    .found (cand_found),
    .idx   (cand_idx)
  );

  assign sel_idx = cand_found ? cand_idx : '0;
  assign sel_oh  = DEPTH'(1) << sel_idx;
  assign others  = |(cand & ~sel_oh);

  assign out_valid = (cnt_q != '0);
  assign in_ready  = (cnt_q != CNT_W'(DEPTH));
  assign full      = ~in_ready;
  assign out_idx   = sel_idx;
  assign out_class = cls_q[sel_idx];
  assign out_tag   = tag_q[sel_idx];

  assign acc_in  = in_valid && in_ready;
  assign deq     = out_valid && out_ready;
  assign skip    = out_valid && out_skip && !out_ready;
  assign cnt_mid = cnt_q - CNT_W'(deq);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TXO_CLS_W-1:0] up_cls;
    logic [TAG_W-1:0]     up_tag;

    if (i < DEPTH - 1) begin : g_up
      assign up_cls = cls_q[i+1];
      assign up_tag = tag_q[i+1];
    end else begin : g_top
      assign up_cls = cls_q[i];
      assign up_tag = tag_q[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cls_q[i] <= '0;
        tag_q[i] <= '0;
        blk_q[i] <= 1'b0;
      end else if (acc_in && (cnt_mid == CNT_W'(i))) begin
        cls_q[i] <= in_class;
        tag_q[i] <= tag_ctr_q;
        blk_q[i] <= 1'b0;
      end else begin
        if (deq && (IDX_W'(i) >= sel_idx)) begin
          cls_q[i] <= up_cls;
          tag_q[i] <= up_tag;
        end
        if (deq || (skip && !others))
          blk_q[i] <= 1'b0;
        else if (skip && sel_oh[i])
          blk_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tag_ctr_q <= '0;
    end else begin
      cnt_q     <= cnt_mid + CNT_W'(acc_in);
      tag_ctr_q <= tag_ctr_q + TAG_W'(acc_in);
    end
  end

endmodule

// File: rtl/txo_checker.sv
module txo_checker
  import txo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [CNT_W-1:0]               cnt,
  input logic [DEPTH*TXO_CLS_W-1:0]     cls_flat,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           out_valid,
  input logic [2:0]                     out_class,
  input logic [IDX_W-1:0]               out_idx,
  input logic                           out_ready
);

  function automatic logic older_in(logic [DEPTH*TXO_CLS_W-1:0] flat,
                                    logic [IDX_W-1:0] idx, int lo, int hi);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((k < int'(idx)) && (int'(flat[k*TXO_CLS_W +: TXO_CLS_W]) >= lo) &&
          (int'(flat[k*TXO_CLS_W +: TXO_CLS_W]) <= hi))
        hit = 1'b1;
    end
    return hit;
  endfunction

  AST_PW_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd0) |-> !older_in(cls_flat, out_idx, 0, 0)); // R2

  AST_CPL_NO_PASS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_class == 3'd3 || out_class == 3'd4))
      |-> !older_in(cls_flat, out_idx, 3, 4)); // R6

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (CNT_W'(out_idx) < cnt)); // R8

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (!out_valid && in_ready)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R9

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH) && !(out_valid && out_ready)) |=> (cnt == CNT_W'(DEPTH))); // R9

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(cnt) == int'($past(cnt)) + int'($past(in_valid && in_ready))
                           - int'($past(out_valid && out_ready)))); // R10

endmodule

bind txo_order_queue txo_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (cnt_q),
  .cls_flat  (cls_flat),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_class (out_class),
  .out_idx   (out_idx),
  .out_ready (out_ready)
);

// File: tb/sim_txo_order_queue.sv
`timescale 1ns/1ps
module sim_txo_order_queue;

  localparam int DEPTH = 8;
  localparam int TAG_W = 8;
  localparam int PW = 0, RQ = 1, WQ = 2, RC = 3, WC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_class = '0;
  logic in_ready, full, out_valid;
  logic [2:0] out_class;
  logic [$clog2(DEPTH)-1:0] out_idx;
  logic [TAG_W-1:0] out_tag;
  logic out_ready = 1'b0;
  logic out_skip = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_cls[$];
  int m_tag[$];
  int m_blk[$];
  int m_ctr = 0;

  always #10 clk = ~clk;

  txo_order_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_ready(in_ready), .full(full), .out_valid(out_valid), .out_class(out_class),
    .out_idx(out_idx), .out_tag(out_tag), .out_ready(out_ready), .out_skip(out_skip)
  );

  task automatic check(string req, bit ok, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pass permissions taken from R2..R7.
  function automatic bit m_pass(int later, int earlier, bit head);
    case (earlier)
      PW: return later == WC;
      RQ: return (later == PW) ? head : (later != RC);
      WQ: return later == PW || later == RC || later == WC;
      default: return later == PW || later == RQ || later == WQ;
    endcase
  endfunction

  function automatic bit m_elig(int i);
    int dh = -1;
    for (int j = 0; j < m_cls.size(); j++)
      if (dh < 0 && (m_cls[j] == RQ || m_cls[j] == WQ)) dh = j;
    for (int j = 0; j < i; j++)
      if (!m_pass(m_cls[i], m_cls[j], j == dh)) return 0;
    return 1;
  endfunction

  function automatic bit m_cand(int i);
    return (m_blk[i] == 0) && m_elig(i);
  endfunction

  function automatic int m_sel();
    for (int i = 0; i < m_cls.size(); i++) if (m_cand(i)) return i;
    return 0;
  endfunction

  task automatic compare_model();
    int n = m_cls.size();
    int s = m_sel();
    check("R8", out_valid == (n > 0), "out_valid", out_valid, n > 0);
    check("R9", in_ready == (n < DEPTH) && full == (n == DEPTH), "in_ready",
          in_ready, n < DEPTH);
    if (n > 0) begin
      check("R8", int'(out_idx) == s, "out_idx", out_idx, s);
      check("R1", int'(out_class) == m_cls[s], "out_class", out_class, m_cls[s]);
      check("R12", int'(out_tag) == m_tag[s], "out_tag", out_tag, m_tag[s]);
    end
  endtask

  task automatic cyc(bit v, int c, bit rdy, bit skp);
    int n, s;
    bit acc, dq, sk, oth;
    @(negedge clk);
    compare_model();
    in_valid = v; in_class = 3'(c); out_ready = rdy; out_skip = skp;
    n = m_cls.size();
    s = m_sel();
    acc = v && (n < DEPTH);
    dq = (n > 0) && rdy;
    sk = (n > 0) && skp && !rdy;
    if (dq) begin
      m_cls.delete(s); m_tag.delete(s); m_blk.delete(s);
      foreach (m_blk[k]) m_blk[k] = 0;
    end else if (sk) begin
      oth = 0;
      for (int k = 0; k < n; k++) if (k != s && m_cand(k)) oth = 1;
      if (oth) m_blk[s] = 1;
      else foreach (m_blk[k]) m_blk[k] = 0;
    end
    if (acc) begin
      m_cls.push_back(c); m_tag.push_back(m_ctr); m_blk.push_back(0);
      m_ctr = (m_ctr + 1) % (1 << TAG_W);
    end
    @(posedge clk);
    #1;
    in_valid = 0; out_ready = 0; out_skip = 0;
  endtask

  task automatic enq(int c);   cyc(1, c, 0, 0); endtask
  task automatic skp();        cyc(0, 0, 0, 1); endtask
  task automatic acc();        cyc(0, 0, 1, 0); endtask
  task automatic drain();
    while (m_cls.size() > 0) acc();
  endtask

  task automatic chk_sel(string req, int idx, int c);
    check(req, out_valid == 1'b1, "out_valid", out_valid, 1);
    check(req, int'(out_idx) == idx, "out_idx", out_idx, idx);
    check(req, int'(out_class) == c, "out_class", out_class, c);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", out_valid == 0, "out_valid after reset", out_valid, 0);
    check("R12", in_ready == 1 && full == 0, "in_ready after reset", in_ready, 1);

    // R3: write completion passes posted write; decline marks rotate (R11)
    enq(PW); enq(WC);
    check("R12", out_tag == 0, "first tag", out_tag, 0);
    chk_sel("R3", 0, PW);
    skp(); chk_sel("R3", 1, WC);
    skp(); chk_sel("R11", 0, PW);
    cyc(0, 0, 1, 1); chk_sel("R11", 0, WC);   // accept wins over decline
    drain();

    // R3: requests and read completion wait behind posted write
    enq(PW); enq(RQ); enq(RC); enq(WQ);
    skp(); chk_sel("R3", 0, PW);
    drain();
    // R2: posted writes in order
    enq(PW); enq(PW);
    skp(); chk_sel("R2", 0, PW);
    drain();

    // R4: posted write passes read request at delayed head, not behind it
    enq(RQ); enq(PW);
    skp(); chk_sel("R4", 1, PW);
    drain();
    enq(WQ); enq(RQ); enq(PW);
    skp(); chk_sel("R4", 0, WQ);
    drain();

    // R5
    enq(WQ); enq(RC);
    skp(); chk_sel("R5", 1, RC);
    drain();
    enq(WQ); enq(WQ);
    skp(); chk_sel("R5", 0, WQ);
    drain();

    // R6
    enq(RC); enq(WQ);
    skp(); chk_sel("R6", 1, WQ);
    drain();
    enq(RC); enq(WC);
    skp(); chk_sel("R6", 0, RC);
    drain();

    // R7
    enq(RQ); enq(RQ);
    skp(); chk_sel("R7", 1, RQ);
    drain();
    enq(RQ); enq(RC);
    skp(); chk_sel("R7", 0, RQ);
    drain();

    // R8: ineligible middle slot skipped
    enq(RC); enq(WC); enq(RQ);
    skp(); chk_sel("R8", 2, RQ);
    drain();

    // R10: removal from the middle keeps younger order
    enq(RQ); enq(RC); enq(PW); enq(WC);
    skp(); chk_sel("R10", 2, PW);
    acc(); chk_sel("R10", 0, RQ);
    acc(); chk_sel("R10", 0, RC);
    acc(); chk_sel("R10", 0, WC);
    acc();
    check("R10", out_valid == 0, "out_valid after drain", out_valid, 0);

    // R9: full refuses, even with simultaneous removal
    for (int k = 0; k < DEPTH; k++) enq(PW);
    check("R9", full == 1 && in_ready == 0, "full", full, 1);
    cyc(1, WC, 0, 0);
    cyc(1, WC, 1, 0);
    for (int k = 0; k < DEPTH - 1; k++) begin
      chk_sel("R9", 0, PW);
      acc();
    end
    check("R9", out_valid == 0, "out_valid after refused enqueues", out_valid, 0);

    // R1/R8/R10/R11/R12: random traffic against model
    for (int t = 0; t < 3000; t++)
      cyc($urandom_range(1, 0) == 1, $urandom_range(4, 0),
          $urandom_range(9, 0) < 3, $urandom_range(9, 0) < 4);
    drain();
    @(negedge clk);
    compare_model();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule